// File: doc/BRIEF.md
# Dual-bank GPIO controller

This block controls 32 general-purpose lines from two complete register banks that sit side by side on one 32-bit word register bus. An ownership register assigns every line to one bank or the other. The owning bank drives that line's output value and output enable, and it sees that line's input and interrupt. One bank is always usable. The other bank, together with the ownership register, answers the bus only while an access-permit input is high. Two software agents of different trust can therefore share the pins, and the trusted side decides which lines the other side controls.

Each pad input passes through a synchronizer. Each line has an interrupt flag per bank. The flag is set while the synchronized level matches that line's polarity bit. Writing ones to the flag register clears flags. A mask register gates the flags, and each bank drives one registered interrupt line built from the masked flags of the lines it owns. Register data crosses the bus in big-endian byte order.

Top module: `gpio_dual_bank`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, all stored registers are zero. This covers outputs, directions, polarities, flags, masks, the auxiliary enable word and ownership. `gpio_out`, `gpio_oe`, `irq_open`, `irq_prot` and `rdata` are 0.
- R2: Ownership bit n set to 1 gives line n to the open bank; 0 gives it to the protected bank. `gpio_out[n]` and `gpio_oe[n]` follow the output and direction bits of the owning bank (direction 1 = drive). They are registered and change one cycle after the register or ownership change.
- R3: Word address = byte offset / 4. Open bank: 0x00 output, 0x04 direction, 0x08 input, 0x0C polarity, 0x10 flag, 0x14 mask, 0x18 mirror. Protected bank: 0x20 output, 0x24 direction, 0x28 input, 0x2C polarity, 0x30 flag, 0x34 mask, 0x38 mirror. 0x1C is a plain read/write auxiliary enable word and 0x3C is ownership. With `permit` low, writes to 0x1C–0x3C are ignored and reads there return 0. The open bank works regardless of `permit`.
- R4: In a bank's output, direction, polarity and mask registers, write data bits for lines that bank does not own are ignored. The same applies to flag-clear bits.
- R5: The input register of a bank returns the synchronized levels ANDed with that bank's ownership. The mirror register returns the synchronized levels of all lines. Both are read-only. A pad change reaches the synchronized level after two clock edges.
- R6: A bank's flag n becomes 1 on the edge after the synchronized level of line n equals its polarity bit (1 = active-high, 0 = active-low), provided that bank owns line n.
- R7: Writing 1 to a flag bit clears that flag on the write edge, and writing 0 leaves it. If the matching level is still present, the flag is 1 again one edge later.
- R8: `irq_open` and `irq_prot` are registered. Each is the OR over its own lines of flag AND mask, taken in the previous cycle.
- R9: Bus data is big-endian. Internal bit n is line n. Internal byte k (bits 8k+7..8k) travels on bus bits 8(3-k)+7..8(3-k) for both `wdata` and `rdata`.
- R10: `rdata` is registered. It shows the addressed word on the edge where `rd_en` is high and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| permit | input | 1 | Unlocks the protected bank, auxiliary word and ownership register |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Word address (byte offset / 4) |
| wdata | input | 32 | Write data, big-endian byte order |
| rdata | output | 32 | Read data, big-endian byte order, registered |
| gpio_in | input | 32 | Pad input levels (asynchronous) |
| gpio_out | output | 32 | Pad output values of the owning banks |
| gpio_oe | output | 32 | Pad output enables of the owning banks |
| irq_open | output | 1 | Interrupt of the open bank |
| irq_prot | output | 1 | Interrupt of the protected bank |

## Verification
Steering is tried by writing all ones into both banks under a split ownership word, then moving ownership to one side. This separates a correct per-line multiplexer from one that ORs the banks or ignores ownership. Interrupts are tried with an active-high level on an open-bank line and an active-low level on a protected-bank line. The flag is read on the cycle right after a clear and again one cycle later, which tells a write-one-to-clear with level re-arming apart from a flag that never clears or a set that wins over the clear. Access gating and unowned-bit masking are tried by writes that should be ignored, each followed by a read-back or port check of the state they could have touched.

// File: rtl/gpio_db_pkg.sv
`timescale 1ns/1ps
package gpio_db_pkg;
  localparam int BUS_W  = 32;
  localparam int WADR_W = 4;

  // slot of a register inside one bank (word address bits 2:0);
  // bit 3 of the word address selects the bank (0 open, 1 protected)
  typedef enum logic [2:0] {
    SL_OUT  = 3'd0,
    SL_DIR  = 3'd1,
    SL_IN   = 3'd2,
    SL_POL  = 3'd3,
    SL_FLAG = 3'd4,
    SL_MASK = 3'd5,
    SL_MIR  = 3'd6,
    SL_AUX  = 3'd7   // bank 0: auxiliary enable word, bank 1: ownership
  } slot_e;

  function automatic logic [BUS_W-1:0] swap_bytes(input logic [BUS_W-1:0] v);
    logic [BUS_W-1:0] r;
    for (int k = 0; k < BUS_W/8; k++)
      r[8*(BUS_W/8-1-k) +: 8] = v[8*k +: 8];
    return r;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  // no reset: the chain simply fills with the pad level
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk)
    stg <= {stg[STAGES-2:0], d};

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_bank.sv
`timescale 1ns/1ps
module gpio_bank #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] owned,
  input  logic [N-1:0] lvl,
  input  logic [N-1:0] wdata,
  input  logic         we_out,
  input  logic         we_dir,
  input  logic         we_pol,
  input  logic         we_flag,
  input  logic         we_mask,
  output logic [N-1:0] out_q,
  output logic [N-1:0] dir_q,
  output logic [N-1:0] pol_q,
  output logic [N-1:0] flag_q,
  output logic [N-1:0] mask_q,
  output logic         irq_q
);
  logic [N-1:0] hit;
  logic [N-1:0] clr;

  function automatic logic [N-1:0] merge(input logic [N-1:0] old_v,
                                         input logic [N-1:0] new_v,
                                         input logic [N-1:0] own_v);
    return (old_v & ~own_v) | (new_v & own_v);
  endfunction

  assign hit = ~(lvl ^ pol_q) & owned;
  assign clr = we_flag ? (wdata & owned) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q  <= '0;
      dir_q  <= '0;
      pol_q  <= '0;
      flag_q <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (we_out)  out_q  <= merge(out_q,  wdata, owned);
      if (we_dir)  dir_q  <= merge(dir_q,  wdata, owned);
      if (we_pol)  pol_q  <= merge(pol_q,  wdata, owned);
      if (we_mask) mask_q <= merge(mask_q, wdata, owned);
      flag_q <= (flag_q | hit) & ~clr;
      irq_q  <= |(flag_q & mask_q & owned);
    end
  end

  AST_UNOWNED_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((out_q ^ $past(out_q)) & ~$past(owned)) == '0)); // R4

  AST_UNOWNED_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((mask_q ^ $past(mask_q)) & ~$past(owned)) == '0)); // R4

  AST_FLAG_SET_ONLY_ON_MATCH: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(hit)) == '0)); // R6

  AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (rst)
    we_flag |=> ((flag_q & $past(wdata & owned)) == '0)); // R7

  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> ($past(mask_q & owned) != '0)); // R8
endmodule

// File: rtl/gpio_dual_bank.sv
`timescale 1ns/1ps
module gpio_dual_bank
  import gpio_db_pkg::*;
#(
  parameter int N_LINES     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               permit,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [WADR_W-1:0]  addr,
  input  logic [BUS_W-1:0]   wdata,
  output logic [BUS_W-1:0]   rdata,
  input  logic [N_LINES-1:0] gpio_in,
  output logic [N_LINES-1:0] gpio_out,
  output logic [N_LINES-1:0] gpio_oe,
  output logic               irq_open,
  output logic               irq_prot
);
  localparam int NBANK = 2;

  slot_e                          slot;
  logic                           bsel;
  logic [BUS_W-1:0]               wd_sw;
  logic [N_LINES-1:0]             wd;
  logic [N_LINES-1:0]             lvl;
  logic [N_LINES-1:0]             own_q;
  logic [N_LINES-1:0]             aux_q;
  logic [NBANK-1:0][N_LINES-1:0]  owned_v;
  logic [NBANK-1:0][N_LINES-1:0]  b_out, b_dir, b_pol, b_flag, b_mask;
  logic [NBANK-1:0]               b_irq;
  logic [NBANK-1:0]               bank_ok;
  logic                           rd_ok;
  logic [N_LINES-1:0]             rd_word;
  logic [BUS_W-1:0]               rd_ext;

  assign slot  = slot_e'(addr[2:0]);
  assign bsel  = addr[3];
  assign wd_sw = swap_bytes(wdata);
  assign wd    = wd_sw[N_LINES-1:0];

  gpio_sync #(.W(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .d   (gpio_in),
    .q   (lvl)
  );

  assign owned_v[0] = own_q;
  assign owned_v[1] = ~own_q;
  assign bank_ok[0] = 1'b1;
  assign bank_ok[1] = permit;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit_b;
    assign hit_b = wr_en && (bsel == b[0]) && bank_ok[b];

    gpio_bank #(.N(N_LINES)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .owned   (owned_v[b]),
      .lvl     (lvl),
      .wdata   (wd),
      .we_out  (hit_b && slot == SL_OUT),
      .we_dir  (hit_b && slot == SL_DIR),
      .we_pol  (hit_b && slot == SL_POL),
      .we_flag (hit_b && slot == SL_FLAG),
      .we_mask (hit_b && slot == SL_MASK),
      .out_q   (b_out[b]),
      .dir_q   (b_dir[b]),
      .pol_q   (b_pol[b]),
      .flag_q  (b_flag[b]),
      .mask_q  (b_mask[b]),
      .irq_q   (b_irq[b])
    );
  end

  // auxiliary enable word and ownership share slot 7, both gated by permit
  always_ff @(posedge clk) begin
    if (rst) begin
      own_q <= '0;
      aux_q <= '0;
    end else if (wr_en && permit && slot == SL_AUX) begin
      if (bsel) own_q <= wd;
      else      aux_q <= wd;
    end
  end

  assign rd_ok = permit || (!bsel && slot != SL_AUX);

  always_comb begin
    case (slot)
      SL_OUT:  rd_word = b_out[bsel];
      SL_DIR:  rd_word = b_dir[bsel];
      SL_IN:   rd_word = lvl & owned_v[bsel];
      SL_POL:  rd_word = b_pol[bsel];
      SL_FLAG: rd_word = b_flag[bsel];
      SL_MASK: rd_word = b_mask[bsel];
      SL_MIR:  rd_word = lvl;
      SL_AUX:  rd_word = bsel ? own_q : aux_q;
      default: rd_word = '0;
    endcase
    rd_ext = '0;
    if (rd_ok) rd_ext[N_LINES-1:0] = rd_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      gpio_out <= '0;
      gpio_oe  <= '0;
    end else begin
      if (rd_en) rdata <= swap_bytes(rd_ext);
      gpio_out <= (b_out[0] & own_q) | (b_out[1] & ~own_q);
      gpio_oe  <= (b_dir[0] & own_q) | (b_dir[1] & ~own_q);
    end
  end

  assign irq_open = b_irq[0];
  assign irq_prot = b_irq[1];

  AST_OWNER_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !permit && addr == 4'hF) |=> $stable(own_q)); // R3

  AST_LOCKED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !permit && addr >= 4'h7) |=> (rdata == '0)); // R3

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata)); // R10

  AST_OE_FROM_OWNER: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((gpio_oe & ~$past(b_dir[0] | b_dir[1])) == '0)); // R2
endmodule

// File: tb/tb_gpio_dual_bank.sv
`timescale 1ns/1ps
module tb_gpio_dual_bank;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          permit = 1'b0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [3:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [N-1:0]  gpio_in = '1;
  logic [N-1:0]  gpio_out;
  logic [N-1:0]  gpio_oe;
  logic          irq_open;
  logic          irq_prot;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        rd_q = 1'b0;

  always #2.5 clk = ~clk;

  gpio_dual_bank dut (
    .clk(clk), .rst(rst), .permit(permit), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .gpio_in(gpio_in),
    .gpio_out(gpio_out), .gpio_oe(gpio_oe), .irq_open(irq_open), .irq_prot(irq_prot)
  );

  function automatic logic [31:0] be(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
    end
  endtask

  // driver tasks: called at a falling edge, return at the next one
  task automatic wr_raw(input logic [5:0] off, input logic [31:0] v);
    wr_en = 1'b1; addr = off[5:2]; wdata = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask
  task automatic wr(input logic [5:0] off, input logic [31:0] v);
    wr_raw(off, be(v));
  endtask
  task automatic rd_raw(input logic [5:0] off, input logic [31:0] exp_v, input string tag);
    exp_q.push_back(exp_v); tag_q.push_back(tag);
    rd_en = 1'b1; addr = off[5:2];
    @(negedge clk);
    rd_en = 1'b0;
  endtask
  task automatic rd(input logic [5:0] off, input logic [31:0] exp_v, input string tag);
    rd_raw(off, be(exp_v), tag);
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops one expected word per read, compares at the falling edge
  always @(posedge clk) rd_q <= rd_en;
  always @(negedge clk) begin
    if (rd_q) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R10: unexpected read result actual %h expected none", rdata);
      end else begin
        check(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    idle(4);
    rst = 1'b0;
    // R1 reset state, first cycle after reset
    check("R1 gpio_out", gpio_out, 32'h0);
    check("R1 gpio_oe", gpio_oe, 32'h0);
    check("R1 irq", {30'h0, irq_open, irq_prot}, 32'h0);
    check("R1 rdata", rdata, 32'h0);
    permit = 1'b1;
    rd(6'h3C, 32'h0, "R1 owner");
    rd(6'h30, 32'h0, "R1 prot flag");
    rd(6'h00, 32'h0, "R1 open out");

    // ownership split: lines 0-15 open, 16-31 protected
    wr(6'h3C, 32'h0000FFFF);
    rd(6'h3C, 32'h0000FFFF, "R3 owner with permit");

    // R9 byte order on write and read
    wr_raw(6'h00, 32'h01020000);
    rd_raw(6'h00, 32'h01020000, "R9 raw readback");
    idle(2);
    check("R9 lines from swapped bytes", gpio_out, 32'h00000201);

    // R2 steering
    wr(6'h04, 32'h0000000F);
    idle(2);
    check("R2 oe open", gpio_oe, 32'h0000000F);
    wr(6'h00, 32'hFFFFFFFF);
    rd(6'h00, 32'h0000FFFF, "R4 open out unowned bits");
    wr(6'h20, 32'hFFFFFFFF);
    wr(6'h24, 32'hFF000000);
    idle(2);
    check("R2 out both banks", gpio_out, 32'hFFFFFFFF);
    check("R2 oe both banks", gpio_oe, 32'hFF00000F);
    wr(6'h3C, 32'hFFFFFFFF);
    idle(2);
    check("R2 out after ownership move", gpio_out, 32'h0000FFFF);
    check("R2 oe after ownership move", gpio_oe, 32'h0000000F);
    wr(6'h3C, 32'h0000FFFF);
    idle(2);
    check("R2 out restored", gpio_out, 32'hFFFFFFFF);

    // R3 access gating
    wr(6'h1C, 32'h12345678);
    rd(6'h1C, 32'h12345678, "R3 aux word");
    permit = 1'b0;
    wr(6'h20, 32'h0);
    wr(6'h3C, 32'h0);
    wr(6'h1C, 32'h0);
    rd(6'h20, 32'h0, "R3 locked read prot out");
    rd(6'h3C, 32'h0, "R3 locked read owner");
    rd(6'h00, 32'h0000FFFF, "R3 open bank while locked");
    idle(2);
    check("R3 locked write ignored at pins", gpio_out, 32'hFFFFFFFF);
    permit = 1'b1;
    rd(6'h3C, 32'h0000FFFF, "R3 owner kept");
    rd(6'h20, 32'hFFFF0000, "R3 prot out kept");
    rd(6'h1C, 32'h12345678, "R3 aux kept");

    // R5 input and mirror
    gpio_in = 32'hA5A53C3C;
    idle(4);
    rd(6'h08, 32'h00003C3C, "R5 open input");
    rd(6'h28, 32'hA5A50000, "R5 prot input");
    rd(6'h18, 32'hA5A53C3C, "R5 open mirror");
    rd(6'h38, 32'hA5A53C3C, "R5 prot mirror");
    wr(6'h08, 32'h0);
    rd(6'h18, 32'hA5A53C3C, "R5 mirror read-only");

    // flags: return to idle level, clear everything
    gpio_in = '1;
    idle(4);
    wr(6'h10, 32'hFFFFFFFF);
    wr(6'h30, 32'hFFFFFFFF);
    rd(6'h10, 32'h0, "R7 open flags cleared");
    rd(6'h30, 32'h0, "R7 prot flags cleared");

    // R6 active-high on line 0
    wr(6'h0C, 32'h00000001);
    idle(3);
    rd(6'h10, 32'h00000001, "R6 active-high flag");
    check("R8 masked irq", {31'h0, irq_open}, 32'h0);
    wr(6'h14, 32'h00000001);
    idle(3);
    check("R8 irq_open", {31'h0, irq_open}, 32'h1);
    check("R8 irq_prot idle", {31'h0, irq_prot}, 32'h0);

    // R7 write-zero and write-one, level re-arm
    wr(6'h10, 32'h0);
    rd(6'h10, 32'h00000001, "R7 write zero keeps flag");
    wr(6'h10, 32'h00000001);
    rd(6'h10, 32'h0, "R7 cleared on write edge");
    rd(6'h10, 32'h00000001, "R7 re-set by level");

    gpio_in = 32'hFFFFFFFE;
    idle(4);
    wr(6'h10, 32'h00000001);
    idle(3);
    rd(6'h10, 32'h0, "R7 stays clear without level");
    check("R8 irq_open drops", {31'h0, irq_open}, 32'h0);

    // R6 active-low on protected line 20
    gpio_in = 32'hFFEFFFFE;
    idle(5);
    rd(6'h30, 32'h00100000, "R6 active-low flag");
    check("R8 prot masked", {31'h0, irq_prot}, 32'h0);
    wr(6'h34, 32'h00100000);
    idle(3);
    check("R8 irq_prot", {31'h0, irq_prot}, 32'h1);
    wr(6'h3C, 32'h0010FFFF);
    idle(3);
    check("R8 irq_prot after ownership loss", {31'h0, irq_prot}, 32'h0);
    check("R8 irq_open unmasked line", {31'h0, irq_open}, 32'h0);
    wr(6'h30, 32'h00100000);
    rd(6'h30, 32'h00100000, "R4 unowned flag clear ignored");
    idle(3);
    check("R10 rdata held", rdata, be(32'h00100000));

    idle(2);
    if (exp_q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL R10: actual %0d reads pending expected 0", exp_q.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule